// File: doc/BRIEF.md
# Staged Crosspoint Routing Map

This block keeps the routing map for a square selector with 34 single-bit data inputs and 34 single-bit data outputs. Each output owns one configuration register. The register holds the number of the input that the output should carry. Software writes and reads these registers through a simple address/data port. Written values first land in a staging copy of the map.

A separate commit strobe copies every staged entry into the active map on one clock edge. The active map drives a 1-bit multiplexer per output. A whole new routing pattern therefore takes effect on all outputs in the same cycle, and no output ever sees a partial update. Reads always return the staged copy, so software can check a pending pattern before it commits it.

Entry values that name no existing input are kept as written, and the output they drive is held low. Addresses beyond the last output register have no effect on the block.

Top module: `xroute_cfg`

## Requirements
- R1: After reset, the staged entry and the active entry of output n both hold n. Each output n therefore carries input n, and a read of address n returns n.
- R2: A write with `cfg_wr` high at address a (0 to 33) stores `cfg_wdata` in staged entry a at that clock edge. From the following cycle, a read of address a returns that value on `cfg_rdata` combinationally.
- R3: A write by itself never changes any output's routing. Until a commit, every output keeps the input selection it had before the write.
- R4: When `cfg_commit` is high at a clock edge, all 34 active entries take the staged values they held before that edge. From the next cycle, every output follows its new entry.
- R5: Reads return the staged entry, even when that entry differs from the active entry.
- R6: An entry value of 34 or above (up to 63) is stored and read back unchanged. Once it is committed, the output it drives is 0 whatever the inputs are.
- R7: Writes to addresses 34 to 255 change neither the staged nor the active map. Reads at those addresses return 0.
- R8: If a write and a commit fall on the same edge, the commit copies the staged value from before the write. The newly written value stays staged and reaches the output only at a later commit.
- R9: Output n equals `din[k]` combinationally, where k is active entry n and k is 33 or less.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Register write enable |
| cfg_addr | input | 8 | Register address for writes and reads |
| cfg_wdata | input | 6 | Write data, an input index |
| cfg_rdata | output | 6 | Staged entry at `cfg_addr`, or 0 when out of range |
| cfg_commit | input | 1 | Copies the staged map into the active map |
| din | input | 34 | Data inputs, bit k is input k |
| dout | output | 34 | Data outputs, bit n is output n |

## Verification
The read port and the output multiplexers contain no registers. A register read is therefore due in the same cycle that the address is presented, and a change on `din` shows on `dout` at once. A write is due on `cfg_rdata` in the first cycle after its edge. A commit is due on `dout` in the first cycle after its edge. The bench changes inputs at falling edges and samples one delay later, so each check observes the state left by the most recent rising edge. When a write and a commit share an edge, the bench compares the outputs against the map from before the write, and the readback against the new value.

// File: rtl/xroute_pkg.sv
package xroute_pkg;
   localparam int XR_N_OUT  = 34;
   localparam int XR_N_IN   = 34;
   localparam int XR_SEL_W  = 6;
   localparam int XR_ADDR_W = 8;

   // number of selector codes addressable by a given entry width
   function automatic int xr_codes(input int sel_w);
      return 1 << sel_w;
   endfunction
endpackage

// File: rtl/xroute_stage_bank.sv
module xroute_stage_bank
   import xroute_pkg::*;
#(
   parameter int N_OUT  = XR_N_OUT,
   parameter int SEL_W  = XR_SEL_W,
   parameter int ADDR_W = XR_ADDR_W
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    wr_en,
   input  logic [ADDR_W-1:0]       addr,
   input  logic [SEL_W-1:0]        wdata,
   output logic [SEL_W-1:0]        rdata,
   output logic [N_OUT*SEL_W-1:0]  stg_flat
);
   localparam logic [ADDR_W-1:0] LAST_A = ADDR_W'(N_OUT - 1);

   logic [SEL_W-1:0] stg [N_OUT];
   logic             in_range;

   assign in_range = (addr <= LAST_A);

   for (genvar n = 0; n < N_OUT; n++) begin : g_entry
      logic hit;
      assign hit = wr_en && (addr == ADDR_W'(n));
      always_ff @(posedge clk) begin
         if (!rst_n)
            stg[n] <= SEL_W'(n);
         else if (hit)
            stg[n] <= wdata;
      end
      assign stg_flat[n*SEL_W +: SEL_W] = stg[n];
   end

   always_comb begin
      rdata = '0;
      for (int n = 0; n < N_OUT; n++) begin
         if (in_range && (addr == ADDR_W'(n)))
            rdata = stg[n];
      end
   end
endmodule

// File: rtl/xroute_active_bank.sv
module xroute_active_bank
   import xroute_pkg::*;
#(
   parameter int N_OUT = XR_N_OUT,
   parameter int SEL_W = XR_SEL_W
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    commit,
   input  logic [N_OUT*SEL_W-1:0]  stg_flat,
   output logic [N_OUT*SEL_W-1:0]  act_flat
);
   for (genvar n = 0; n < N_OUT; n++) begin : g_entry
      always_ff @(posedge clk) begin
         if (!rst_n)
            act_flat[n*SEL_W +: SEL_W] <= SEL_W'(n);
         else if (commit)
            act_flat[n*SEL_W +: SEL_W] <= stg_flat[n*SEL_W +: SEL_W];
      end
   end
endmodule

// File: rtl/xroute_out_mux.sv
module xroute_out_mux
   import xroute_pkg::*;
#(
   parameter int N_OUT = XR_N_OUT,
   parameter int N_IN  = XR_N_IN,
   parameter int SEL_W = XR_SEL_W
) (
   input  logic [N_OUT*SEL_W-1:0]  act_flat,
   input  logic [N_IN-1:0]         din,
   output logic [N_OUT-1:0]        dout
);
   localparam int CODES = xr_codes(SEL_W);

   logic [CODES-1:0] din_ext;

   // every selector code indexes a defined bit; codes past the inputs read 0
   if (N_IN == CODES) begin : g_full
      assign din_ext = din;
   end else begin : g_pad
      assign din_ext = {{(CODES - N_IN){1'b0}}, din};
   end

   for (genvar n = 0; n < N_OUT; n++) begin : g_out
      logic [SEL_W-1:0] sel;
      assign sel     = act_flat[n*SEL_W +: SEL_W];
      assign dout[n] = din_ext[sel];
   end
endmodule

// File: rtl/xroute_cfg.sv
module xroute_cfg
   import xroute_pkg::*;
#(
   parameter int N_OUT  = XR_N_OUT,
   parameter int N_IN   = XR_N_IN,
   parameter int SEL_W  = XR_SEL_W,
   parameter int ADDR_W = XR_ADDR_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_wr,
   input  logic [ADDR_W-1:0] cfg_addr,
   input  logic [SEL_W-1:0]  cfg_wdata,
   output logic [SEL_W-1:0]  cfg_rdata,
   input  logic              cfg_commit,
   input  logic [N_IN-1:0]   din,
   output logic [N_OUT-1:0]  dout
);
   if (SEL_W < $clog2(N_IN) || SEL_W < $clog2(N_OUT)) begin : g_bad_sel
      $error("xroute_cfg: SEL_W too narrow for the input or output count");
   end
   if ((1 << ADDR_W) < N_OUT) begin : g_bad_addr
      $error("xroute_cfg: ADDR_W cannot reach every output register");
   end

   logic [N_OUT*SEL_W-1:0] stg_flat;
   logic [N_OUT*SEL_W-1:0] act_flat;

   xroute_stage_bank #(.N_OUT(N_OUT), .SEL_W(SEL_W), .ADDR_W(ADDR_W)) u_stage (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (cfg_wr),
      .addr     (cfg_addr),
      .wdata    (cfg_wdata),
      .rdata    (cfg_rdata),
      .stg_flat (stg_flat)
   );

   xroute_active_bank #(.N_OUT(N_OUT), .SEL_W(SEL_W)) u_active (
      .clk      (clk),
      .rst_n    (rst_n),
      .commit   (cfg_commit),
      .stg_flat (stg_flat),
      .act_flat (act_flat)
   );

   xroute_out_mux #(.N_OUT(N_OUT), .N_IN(N_IN), .SEL_W(SEL_W)) u_mux (
      .act_flat (act_flat),
      .din      (din),
      .dout     (dout)
   );
endmodule

// File: rtl/xroute_cfg_chk.sv
module xroute_cfg_chk #(
   parameter int N_OUT  = 34,
   parameter int N_IN   = 34,
   parameter int SEL_W  = 6,
   parameter int ADDR_W = 8
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    cfg_wr,
   input logic [ADDR_W-1:0]       cfg_addr,
   input logic [SEL_W-1:0]        cfg_wdata,
   input logic [SEL_W-1:0]        cfg_rdata,
   input logic                    cfg_commit,
   input logic [N_IN-1:0]         din,
   input logic [N_OUT-1:0]        dout,
   input logic [N_OUT*SEL_W-1:0]  stg_flat,
   input logic [N_OUT*SEL_W-1:0]  act_flat
);
   localparam logic [ADDR_W-1:0] LAST_A = ADDR_W'(N_OUT - 1);
   localparam logic [SEL_W-1:0]  LAST_I = SEL_W'(N_IN - 1);

   // R7: addresses past the last register read as zero
   a_r7_high_addr_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_addr > LAST_A) |-> (cfg_rdata == '0));

   // R7: a write past the last register leaves the staged map unchanged
   a_r7_high_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_wr && cfg_addr > LAST_A) |=> $stable(stg_flat));

   // R2: a write is visible on the read port next cycle at the same address
   a_r2_write_readback: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_wr && cfg_addr <= LAST_A) ##1 (cfg_addr == $past(cfg_addr))
         |-> (cfg_rdata == $past(cfg_wdata)));

   // R3: without a commit the active map holds
   a_r3_no_commit_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_commit |=> $stable(act_flat));

   // R4 and R8: a commit copies the pre-edge staged map
   a_r4_commit_copy: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_commit |=> (act_flat == $past(stg_flat)));

   for (genvar n = 0; n < N_OUT; n++) begin : g_out
      // R6: an active entry beyond the inputs drives zero
      a_r6_bad_index_zero: assert property (@(posedge clk) disable iff (!rst_n)
         (act_flat[n*SEL_W +: SEL_W] > LAST_I) |-> (dout[n] == 1'b0));
      // R9: a valid active entry forwards its input
      a_r9_forward: assert property (@(posedge clk) disable iff (!rst_n)
         (act_flat[n*SEL_W +: SEL_W] <= LAST_I)
            |-> (dout[n] == din[act_flat[n*SEL_W +: SEL_W]]));
   end
endmodule

bind xroute_cfg xroute_cfg_chk #(
   .N_OUT(N_OUT), .N_IN(N_IN), .SEL_W(SEL_W), .ADDR_W(ADDR_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .cfg_wr     (cfg_wr),
   .cfg_addr   (cfg_addr),
   .cfg_wdata  (cfg_wdata),
   .cfg_rdata  (cfg_rdata),
   .cfg_commit (cfg_commit),
   .din        (din),
   .dout       (dout),
   .stg_flat   (stg_flat),
   .act_flat   (act_flat)
);

// File: tb/xroute_cfg_bench.sv
module xroute_cfg_bench;
   localparam int CLK_PERIOD = 10;
   localparam int NO = 34;
   localparam int NI = 34;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_wr = 1'b0;
   logic [7:0]  cfg_addr = '0;
   logic [5:0]  cfg_wdata = '0;
   logic [5:0]  cfg_rdata;
   logic        cfg_commit = 1'b0;
   logic [NI-1:0] din = '0;
   logic [NO-1:0] dout;

   int checks = 0;
   int errors = 0;
   bit done = 0;
   int m_stg [NO];
   int m_act [NO];

   always #(CLK_PERIOD/2) clk = ~clk;

   xroute_cfg u_xroute_cfg (
      .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .cfg_commit(cfg_commit),
      .din(din), .dout(dout)
   );

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   function automatic logic [NO-1:0] exp_dout(input logic [NI-1:0] d);
      logic [NO-1:0] r;
      for (int n = 0; n < NO; n++) r[n] = (m_act[n] < NI) ? d[m_act[n]] : 1'b0;
      return r;
   endfunction

   // drive a pattern and compare all outputs
   task automatic check_dout_pat(input logic [NI-1:0] d, input string req);
      @(negedge clk);
      din = d;
      #1;
      chk(dout === exp_dout(d), req, longint'(dout), longint'(exp_dout(d)));
   endtask

   task automatic check_dout_all(input string req);
      for (int k = 0; k < NI; k++) check_dout_pat(NI'(1) << k, req);
      check_dout_pat('0, req);
      check_dout_pat('1, req);
      check_dout_pat(34'h2_AAAA_AAAA, req);
      check_dout_pat(34'h1_5555_5555, req);
      check_dout_pat(34'h3_0F0F_1234, req);
   endtask

   task automatic check_rd(input int a, input string req);
      int e;
      @(negedge clk);
      cfg_addr = 8'(a);
      #1;
      e = (a < NO) ? m_stg[a] : 0;
      chk(cfg_rdata === 6'(e), req, longint'(cfg_rdata), longint'(e));
   endtask

   task automatic wr(input int a, input int d);
      @(negedge clk);
      cfg_wr = 1'b1; cfg_addr = 8'(a); cfg_wdata = 6'(d);
      @(negedge clk);
      cfg_wr = 1'b0;
      if (a < NO) m_stg[a] = d;
   endtask

   task automatic commit();
      @(negedge clk);
      cfg_commit = 1'b1;
      @(negedge clk);
      cfg_commit = 1'b0;
      for (int n = 0; n < NO; n++) m_act[n] = m_stg[n];
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      for (int n = 0; n < NO; n++) begin m_stg[n] = n; m_act[n] = n; end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset map is identity in both copies
      for (int a = 0; a < NO; a++) check_rd(a, "R1");
      check_dout_all("R1");

      // R2 and R3: reversed map staged, outputs unchanged
      for (int a = 0; a < NO; a++) wr(a, NO - 1 - a);
      for (int a = 0; a < NO; a++) check_rd(a, "R2");
      check_dout_all("R3");

      // R4 and R9: commit applies the whole map at once
      commit();
      check_dout_all("R4");
      check_dout_all("R9");

      // R5: staged differs from active, reads show staged
      wr(3, 17); wr(20, 0); wr(33, 33);
      check_rd(3, "R5"); check_rd(20, "R5"); check_rd(33, "R5");
      check_dout_all("R3");
      commit();
      check_dout_all("R4");

      // R6: out-of-range entries
      wr(0, 34); wr(5, 40); wr(33, 63);
      check_rd(0, "R6"); check_rd(5, "R6"); check_rd(33, "R6");
      commit();
      check_dout_all("R6");

      // R7: writes above the last register are ignored
      for (int a = NO; a < 256; a++) wr(a, 7);
      for (int a = 0; a < 256; a++) check_rd(a, "R7");
      commit();
      check_dout_all("R7");

      // R8: write and commit on one edge
      @(negedge clk);
      cfg_wr = 1'b1; cfg_addr = 8'd2; cfg_wdata = 6'd9; cfg_commit = 1'b1;
      @(negedge clk);
      cfg_wr = 1'b0; cfg_commit = 1'b0;
      for (int n = 0; n < NO; n++) m_act[n] = m_stg[n];
      m_stg[2] = 9;
      check_dout_all("R8");
      check_rd(2, "R8");
      commit();
      check_dout_all("R8");

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule